// File: doc/BRIEF.md
# Flat Access Aperture Router

This block sits in front of the vector memory path. Each cycle it may take one flat or scalar-load access, given as a start byte address, a payload length and the addressing-mode bits of the issuing dispatch. It decides where the access goes: the on-chip shared memory, the private scratch memory or the ordinary global memory path. It also raises a violation flag that the trap logic can report.

Two mode bits select the pointer interpretation. With the translation bit clear, the pointer is 64 bits wide and the pointer-width bit is ignored. With the translation bit set, the pointer-width bit chooses between 64-bit and 32-bit pointers. In the 64-bit interpretations, the shared and private windows are programmed as inclusive ranges of 64KB pages, and they are placed in the non-canonical hole of the address space. In the 32-bit interpretation, each window is a single 64KB page. A page value of zero switches that window off.

The route is worked out combinationally from both the first and the last byte of the payload. The result is presented one clock later on a registered output stage.

Top module: `flat_ape_router`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid access, out_valid is 0, out_dest is 2'b00 and out_viol is 0.
- R2: An access presented with in_valid=1 appears on the outputs exactly one clock later with out_valid=1. A cycle with in_valid=0 yields out_valid=0, out_dest=2'b00 and out_viol=0 on the next clock.
- R3: With in_atc=0 the pointer is 64 bits wide whatever in_ptr32 holds. With in_atc=1 and in_ptr32=1 only in_addr[31:0] is used, and the upper address bits have no effect.
- R4: In 64-bit mode a byte is inside a window when its page addr[63:16] lies between that window's base and limit page, both ends included. An access whose bytes all lie in the shared window gets out_dest=2'b10. One whose bytes all lie in the private window gets out_dest=2'b11.
- R5: In 32-bit mode a window's 16-bit page value is compared with addr[31:16]. A nonzero value makes the window exactly that one 64KB page. A zero value disables the window.
- R6: In 64-bit mode a byte outside both windows lies in the hole when addr[63:47] is neither all zeros nor all ones. A flat access whose first byte lies in the hole raises out_viol=1.
- R7: The last byte is start + in_len_m1, where in_len_m1 is the length minus 1 (1..64 bytes). The sum wraps modulo 2^64, or modulo 2^32 in 32-bit mode. Every byte belongs to one class: shared, private, global or hole. A flat access whose first and last byte fall in different classes raises out_viol=1.
- R8: A violating access is given out_dest=2'b00 (none).
- R9: A scalar load (in_is_flat=0) never raises out_viol. It is routed by the class of its first byte, and the hole class maps to global (2'b01).
- R10: A non-violating flat access whose bytes lie outside both windows, including any access in 32-bit mode with both windows off, gets out_dest=2'b01 (global).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access present this cycle |
| in_addr | input | ADDR_W | Start byte address |
| in_len_m1 | input | LEN_W | Payload length minus 1 |
| in_atc | input | 1 | Translation mode bit of the dispatch |
| in_ptr32 | input | 1 | 32-bit pointer select, used only when in_atc=1 |
| in_is_flat | input | 1 | 1 for a flat vector op, 0 for a scalar load |
| cfg_shr_base | input | ADDR_W-APE_SHIFT | Shared window first page, 64-bit modes |
| cfg_shr_limit | input | ADDR_W-APE_SHIFT | Shared window last page, 64-bit modes |
| cfg_prv_base | input | ADDR_W-APE_SHIFT | Private window first page, 64-bit modes |
| cfg_prv_limit | input | ADDR_W-APE_SHIFT | Private window last page, 64-bit modes |
| cfg_shr_page32 | input | NARROW_W-APE_SHIFT | Shared page in 32-bit mode, 0 disables it |
| cfg_prv_page32 | input | NARROW_W-APE_SHIFT | Private page in 32-bit mode, 0 disables it |
| out_valid | output | 1 | Registered result valid |
| out_dest | output | 2 | 00 none, 01 global, 10 shared, 11 private |
| out_viol | output | 1 | Memory violation flag |

## Verification
Random addresses are drawn from seven pools: low canonical, high canonical, the hole, and bands of bytes around each window's first and last byte. The windows' edges are therefore hit from both sides, and payloads of random length cross them in both directions. The pools separate in-window hits from off-by-one range compares, and hole violations from straddle violations.

The mode bits and the op type are randomised together. This shows that the pointer-width bit matters only with the translation bit set, and that scalar loads never trap. Directed cases cover the following:
- the exact first and last byte of a window;
- the canonical/hole boundary;
- a payload running from the shared 32-bit page into the adjacent private page;
- junk in the upper address bits in 32-bit mode;
- zeroed 32-bit window pages, which would otherwise match page 0.

// File: rtl/flat_ape_pkg.sv
package flat_ape_pkg;

   typedef enum logic [1:0] {
      DST_NONE    = 2'b00,
      DST_GLOBAL  = 2'b01,
      DST_SHARED  = 2'b10,
      DST_PRIVATE = 2'b11
   } dest_e;

   typedef enum logic [1:0] {
      CLS_GLOBAL  = 2'd0,
      CLS_SHARED  = 2'd1,
      CLS_PRIVATE = 2'd2,
      CLS_HOLE    = 2'd3
   } cls_e;

   // window index 0 is shared, index 1 is private
   localparam int unsigned APE_COUNT = 2;
   localparam int unsigned APE_SHR   = 0;
   localparam int unsigned APE_PRV   = 1;

   function automatic dest_e cls_to_dest(input cls_e c);
      case (c)
         CLS_SHARED:  return DST_SHARED;
         CLS_PRIVATE: return DST_PRIVATE;
         default:     return DST_GLOBAL;
      endcase
   endfunction

endpackage

// File: rtl/flat_ape_match.sv
module flat_ape_match #(
   parameter int unsigned PAGE_W = 48
) (
   input  logic              en,
   input  logic [PAGE_W-1:0] page,
   input  logic [PAGE_W-1:0] lo,
   input  logic [PAGE_W-1:0] hi,
   output logic              hit
);

   logic ge_lo;
   logic le_hi;

   always_comb begin
      ge_lo = (page >= lo);
      le_hi = (page <= hi);
      hit   = en & ge_lo & le_hi;
   end

endmodule

// File: rtl/flat_ape_classify.sv
module flat_ape_classify
   import flat_ape_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned APE_SHIFT = 16,
   parameter int unsigned NARROW_W  = 32,
   parameter int unsigned HOLE_LSB  = 47
) (
   input  logic [ADDR_W-1:0]                                   addr,
   input  logic                                                narrow,
   input  logic [APE_COUNT-1:0][ADDR_W-APE_SHIFT-1:0]          wide_lo,
   input  logic [APE_COUNT-1:0][ADDR_W-APE_SHIFT-1:0]          wide_hi,
   input  logic [APE_COUNT-1:0][NARROW_W-APE_SHIFT-1:0]        narrow_pg,
   output cls_e                                                cls
);

   localparam int unsigned PAGE_W  = ADDR_W - APE_SHIFT;
   localparam int unsigned NPAGE_W = NARROW_W - APE_SHIFT;
   localparam int unsigned TOP_W   = ADDR_W - HOLE_LSB;
   localparam int unsigned PAD_W   = PAGE_W - NPAGE_W;

   logic [PAGE_W-1:0]    page_sel;
   logic [TOP_W-1:0]     top_bits;
   logic                 in_hole;
   logic [APE_COUNT-1:0] hit;

   always_comb begin
      if (narrow) page_sel = {{PAD_W{1'b0}}, addr[NARROW_W-1:APE_SHIFT]};
      else        page_sel = addr[ADDR_W-1:APE_SHIFT];
   end

   generate
      for (genvar i = 0; i < APE_COUNT; i++) begin : g_ape
         logic [PAGE_W-1:0] lo_sel;
         logic [PAGE_W-1:0] hi_sel;
         logic              en_sel;

         always_comb begin
            if (narrow) begin
               lo_sel = {{PAD_W{1'b0}}, narrow_pg[i]};
               hi_sel = {{PAD_W{1'b0}}, narrow_pg[i]};
               en_sel = |narrow_pg[i];
            end else begin
               lo_sel = wide_lo[i];
               hi_sel = wide_hi[i];
               en_sel = 1'b1;
            end
         end

         flat_ape_match #(.PAGE_W(PAGE_W)) u_match (
            .en   (en_sel),
            .page (page_sel),
            .lo   (lo_sel),
            .hi   (hi_sel),
            .hit  (hit[i])
         );
      end
   endgenerate

   always_comb begin
      top_bits = addr[ADDR_W-1:HOLE_LSB];
      in_hole  = !narrow && (|top_bits) && !(&top_bits);
      if (hit[APE_SHR])      cls = CLS_SHARED;
      else if (hit[APE_PRV]) cls = CLS_PRIVATE;
      else if (in_hole)      cls = CLS_HOLE;
      else                   cls = CLS_GLOBAL;
   end

endmodule

// File: rtl/flat_ape_router.sv
module flat_ape_router
   import flat_ape_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned APE_SHIFT = 16,
   parameter int unsigned NARROW_W  = 32,
   parameter int unsigned HOLE_LSB  = 47,
   parameter int unsigned LEN_W     = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic [ADDR_W-1:0]               in_addr,
   input  logic [LEN_W-1:0]                in_len_m1,
   input  logic                            in_atc,
   input  logic                            in_ptr32,
   input  logic                            in_is_flat,
   input  logic [ADDR_W-APE_SHIFT-1:0]     cfg_shr_base,
   input  logic [ADDR_W-APE_SHIFT-1:0]     cfg_shr_limit,
   input  logic [ADDR_W-APE_SHIFT-1:0]     cfg_prv_base,
   input  logic [ADDR_W-APE_SHIFT-1:0]     cfg_prv_limit,
   input  logic [NARROW_W-APE_SHIFT-1:0]   cfg_shr_page32,
   input  logic [NARROW_W-APE_SHIFT-1:0]   cfg_prv_page32,
   output logic                            out_valid,
   output logic [1:0]                      out_dest,
   output logic                            out_viol
);

   localparam int unsigned PAGE_W  = ADDR_W - APE_SHIFT;
   localparam int unsigned NPAGE_W = NARROW_W - APE_SHIFT;
   localparam int unsigned ENDS    = 2;

   // elaboration-time parameter checks
   generate
      if (APE_SHIFT >= NARROW_W) begin : g_bad_shift
         $error("APE_SHIFT must be below NARROW_W");
      end
      if (NARROW_W >= HOLE_LSB) begin : g_bad_narrow
         $error("NARROW_W must be below HOLE_LSB");
      end
      if (HOLE_LSB >= ADDR_W) begin : g_bad_hole
         $error("HOLE_LSB must be below ADDR_W");
      end
      if (LEN_W > APE_SHIFT) begin : g_bad_len
         $error("payload may not exceed one window page");
      end
   endgenerate

   logic                                  narrow;
   logic [ADDR_W-1:0]                     last_addr;
   logic [ENDS-1:0][ADDR_W-1:0]           end_addr;
   cls_e                                  end_cls [ENDS];
   logic [APE_COUNT-1:0][PAGE_W-1:0]      wide_lo;
   logic [APE_COUNT-1:0][PAGE_W-1:0]      wide_hi;
   logic [APE_COUNT-1:0][NPAGE_W-1:0]     narrow_pg;
   logic                                  straddle;
   logic                                  hole_start;
   logic                                  viol_c;
   dest_e                                 dest_c;

   // mode decode: the pointer-width bit only counts with translation on
   always_comb begin
      narrow = in_atc & in_ptr32;
   end

   // one full-width adder; its low bits give the 32-bit wrap for free
   always_comb begin
      last_addr   = in_addr + {{(ADDR_W-LEN_W){1'b0}}, in_len_m1};
      end_addr[0] = in_addr;
      end_addr[1] = last_addr;
   end

   always_comb begin
      wide_lo[APE_SHR]   = cfg_shr_base;
      wide_hi[APE_SHR]   = cfg_shr_limit;
      wide_lo[APE_PRV]   = cfg_prv_base;
      wide_hi[APE_PRV]   = cfg_prv_limit;
      narrow_pg[APE_SHR] = cfg_shr_page32;
      narrow_pg[APE_PRV] = cfg_prv_page32;
   end

   generate
      for (genvar e = 0; e < ENDS; e++) begin : g_end
         flat_ape_classify #(
            .ADDR_W    (ADDR_W),
            .APE_SHIFT (APE_SHIFT),
            .NARROW_W  (NARROW_W),
            .HOLE_LSB  (HOLE_LSB)
         ) u_cls (
            .addr      (end_addr[e]),
            .narrow    (narrow),
            .wide_lo   (wide_lo),
            .wide_hi   (wide_hi),
            .narrow_pg (narrow_pg),
            .cls       (end_cls[e])
         );
      end
   endgenerate

   always_comb begin
      straddle   = (end_cls[0] != end_cls[1]);
      hole_start = (end_cls[0] == CLS_HOLE);
      viol_c     = in_is_flat & (straddle | hole_start);
      dest_c     = viol_c ? DST_NONE : cls_to_dest(end_cls[0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_dest  <= DST_NONE;
         out_viol  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_dest  <= in_valid ? dest_c : DST_NONE;
         out_viol  <= in_valid & viol_c;
      end
   end

endmodule

// File: rtl/flat_ape_router_chk.sv
module flat_ape_router_chk #(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned APE_SHIFT = 16,
   parameter int unsigned NARROW_W  = 32,
   parameter int unsigned HOLE_LSB  = 47,
   parameter int unsigned LEN_W     = 6
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            in_valid,
   input logic [ADDR_W-1:0]               in_addr,
   input logic                            in_atc,
   input logic                            in_ptr32,
   input logic                            in_is_flat,
   input logic [ADDR_W-APE_SHIFT-1:0]     cfg_shr_base,
   input logic [ADDR_W-APE_SHIFT-1:0]     cfg_shr_limit,
   input logic [ADDR_W-APE_SHIFT-1:0]     cfg_prv_base,
   input logic [ADDR_W-APE_SHIFT-1:0]     cfg_prv_limit,
   input logic [NARROW_W-APE_SHIFT-1:0]   cfg_shr_page32,
   input logic [NARROW_W-APE_SHIFT-1:0]   cfg_prv_page32,
   input logic                            out_valid,
   input logic [1:0]                      out_dest,
   input logic                            out_viol
);

   logic                       wide_mode;
   logic [ADDR_W-HOLE_LSB-1:0] top;
   logic                       start_hole;
   logic [ADDR_W-APE_SHIFT-1:0] pg;
   logic                       in_any_wide;

   always_comb begin
      wide_mode   = !(in_atc && in_ptr32);
      top         = in_addr[ADDR_W-1:HOLE_LSB];
      start_hole  = (|top) && !(&top);
      pg          = in_addr[ADDR_W-1:APE_SHIFT];
      in_any_wide = (pg >= cfg_shr_base && pg <= cfg_shr_limit) ||
                    (pg >= cfg_prv_base && pg <= cfg_prv_limit);
   end

   assert_valid_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && out_dest == 2'b00 && !out_viol));

   assert_viol_unrouted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_viol |-> (out_dest == 2'b00 && out_valid));

   assert_scalar_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_is_flat) |=> (!out_viol && out_dest != 2'b00));

   assert_off_windows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide_mode && cfg_shr_page32 == '0 && cfg_prv_page32 == '0)
      |=> (out_dest == 2'b01 && !out_viol));

   assert_hole_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_is_flat && wide_mode && start_hole && !in_any_wide)
      |=> out_viol);

endmodule

bind flat_ape_router flat_ape_router_chk #(
   .ADDR_W    (ADDR_W),
   .APE_SHIFT (APE_SHIFT),
   .NARROW_W  (NARROW_W),
   .HOLE_LSB  (HOLE_LSB),
   .LEN_W     (LEN_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .in_addr        (in_addr),
   .in_atc         (in_atc),
   .in_ptr32       (in_ptr32),
   .in_is_flat     (in_is_flat),
   .cfg_shr_base   (cfg_shr_base),
   .cfg_shr_limit  (cfg_shr_limit),
   .cfg_prv_base   (cfg_prv_base),
   .cfg_prv_limit  (cfg_prv_limit),
   .cfg_shr_page32 (cfg_shr_page32),
   .cfg_prv_page32 (cfg_prv_page32),
   .out_valid      (out_valid),
   .out_dest       (out_dest),
   .out_viol       (out_viol)
);

// File: tb/flat_ape_router_tb.sv
`timescale 1ns/1ps
module flat_ape_router_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_addr = '0;
   logic [5:0]  in_len_m1 = '0;
   logic        in_atc = 1'b0;
   logic        in_ptr32 = 1'b0;
   logic        in_is_flat = 1'b0;
   logic [47:0] shr_base = 48'h0001_0000_0000;
   logic [47:0] shr_lim  = 48'h0001_0000_FFFF;
   logic [47:0] prv_base = 48'h0002_0000_0000;
   logic [47:0] prv_lim  = 48'h0002_0000_FFFF;
   logic [15:0] shr32    = 16'h8000;
   logic [15:0] prv32    = 16'h8001;
   logic        out_valid;
   logic [1:0]  out_dest;
   logic        out_viol;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2 clk = ~clk;

   flat_ape_router u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .in_len_m1(in_len_m1), .in_atc(in_atc), .in_ptr32(in_ptr32),
      .in_is_flat(in_is_flat), .cfg_shr_base(shr_base), .cfg_shr_limit(shr_lim),
      .cfg_prv_base(prv_base), .cfg_prv_limit(prv_lim),
      .cfg_shr_page32(shr32), .cfg_prv_page32(prv32),
      .out_valid(out_valid), .out_dest(out_dest), .out_viol(out_viol)
   );

   // class: 0 global, 1 shared, 2 private, 3 hole
   function automatic logic [1:0] cls_of(input logic [63:0] a, input bit narrow);
      logic [31:0] a32;
      a32 = a[31:0];
      if (narrow) begin
         if (shr32 != 0 && a32 >= {shr32, 16'h0} && a32 <= {shr32, 16'hFFFF}) return 2'd1;
         if (prv32 != 0 && a32 >= {prv32, 16'h0} && a32 <= {prv32, 16'hFFFF}) return 2'd2;
         return 2'd0;
      end
      if (a >= {shr_base, 16'h0} && a <= {shr_lim, 16'hFFFF}) return 2'd1;
      if (a >= {prv_base, 16'h0} && a <= {prv_lim, 16'hFFFF}) return 2'd2;
      if (a[63:47] != 17'h0 && a[63:47] != 17'h1FFFF) return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic [2:0] expect_of(input logic [63:0] a, input logic [5:0] l,
                                            input bit atc, input bit p32, input bit flat);
      bit          narrow;
      logic [1:0]  c0, c1;
      bit          viol;
      logic [1:0]  dest;
      narrow = atc && p32;
      c0 = cls_of(a, narrow);
      c1 = cls_of(a + {58'h0, l}, narrow);
      viol = flat && (c0 != c1 || c0 == 2'd3);
      if (viol)            dest = 2'b00;
      else if (c0 == 2'd1) dest = 2'b10;
      else if (c0 == 2'd2) dest = 2'b11;
      else                 dest = 2'b01;
      return {viol, dest};
   endfunction

   // called at a falling edge; checks one clock later at the next falling edge
   task automatic access(input logic [63:0] a, input logic [5:0] l, input bit atc,
                         input bit p32, input bit flat, input string tag);
      logic [2:0] e;
      in_valid = 1'b1; in_addr = a; in_len_m1 = l;
      in_atc = atc; in_ptr32 = p32; in_is_flat = flat;
      e = expect_of(a, l, atc, p32, flat);
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b1 || out_dest !== e[1:0] || out_viol !== e[2]) begin
         n_fail++;
         $display("FAIL %s addr=%h len_m1=%0d: got valid=%0b dest=%0d viol=%0b expected valid=1 dest=%0d viol=%0b",
                  tag, a, l, out_valid, out_dest, out_viol, e[1:0], e[2]);
      end
   endtask

   task automatic idle(input string tag);
      in_valid = 1'b0; in_addr = 64'h4000_0000_0000_0000; in_is_flat = 1'b1;
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || out_dest !== 2'b00 || out_viol !== 1'b0) begin
         n_fail++;
         $display("FAIL %s: got valid=%0b dest=%0d viol=%0b expected valid=0 dest=0 viol=0",
                  tag, out_valid, out_dest, out_viol);
      end
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   function automatic logic [63:0] pick_addr(input bit narrow);
      logic [63:0] a;
      int sel;
      sel = int'($urandom % 7);
      if (narrow) begin
         a = rnd64();
         case (sel)
            0: a[31:0] = {shr32, 16'h0} + 32'($urandom % 128) - 32'd64;
            1: a[31:0] = {shr32, 16'hFFFF} + 32'($urandom % 128) - 32'd64;
            2: a[31:0] = {prv32, 16'hFFFF} + 32'($urandom % 128) - 32'd64;
            3: a[31:0] = 32'hFFFF_FFC0 + 32'($urandom % 64);
            4: a[31:0] = 32'($urandom % 128);
            default: ;
         endcase
         return a;
      end
      case (sel)
         0: a = rnd64() & 64'h0000_7FFF_FFFF_FFFF;
         1: a = rnd64() | 64'hFFFF_8000_0000_0000;
         2: a = rnd64() | 64'h4000_0000_0000_0000;
         3: a = {shr_base, 16'h0} + 64'($urandom % 128) - 64'd64;
         4: a = {shr_lim, 16'hFFFF} + 64'($urandom % 128) - 64'd64;
         5: a = {prv_base, 16'h0} + 64'($urandom % 128) - 64'd64;
         default: a = {prv_lim, 16'hFFFF} + 64'($urandom % 128) - 64'd64;
      endcase
      return a;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state with a request pending at the input
      in_valid = 1'b1; in_is_flat = 1'b1; in_addr = 64'h4000_0000_0000_0000;
      repeat (3) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || out_dest !== 2'b00 || out_viol !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset: got valid=%0b dest=%0d viol=%0b expected 0 0 0",
                  out_valid, out_dest, out_viol);
      end
      in_valid = 1'b0;
      rst_n = 1'b1;
      idle("R1 after reset release");

      // R4: window edges, both ends inclusive
      access({shr_base, 16'h0}, 6'd0, 1'b1, 1'b0, 1'b1, "R4 shared first byte");
      access({shr_lim, 16'hFFFF}, 6'd0, 1'b1, 1'b0, 1'b1, "R4 shared last byte");
      access({prv_base, 16'h0}, 6'd63, 1'b0, 1'b0, 1'b1, "R4 private first page");
      idle("R2 idle cycle");
      // R7: payload leaves the shared window into the hole
      access({shr_lim, 16'hFFF0}, 6'd31, 1'b1, 1'b0, 1'b1, "R7 straddle shared->hole");
      // R9: same access as scalar routes by first byte without trap
      access({shr_lim, 16'hFFF0}, 6'd31, 1'b1, 1'b0, 1'b0, "R9 scalar straddle");
      // R6 / R8: hole access traps for flat, not for scalar
      access(64'h4000_0000_0000_0000, 6'd3, 1'b1, 1'b0, 1'b1, "R6 R8 hole flat");
      access(64'h4000_0000_0000_0000, 6'd3, 1'b1, 1'b0, 1'b0, "R9 hole scalar");
      // R10: canonical accesses go global
      access(64'h0000_0000_1234_5678, 6'd7, 1'b0, 1'b0, 1'b1, "R10 low canonical");
      access(64'hFFFF_8000_0000_0000, 6'd7, 1'b1, 1'b0, 1'b1, "R10 high canonical");
      // R7: canonical low end running into the hole
      access(64'h0000_7FFF_FFFF_FFF8, 6'd15, 1'b1, 1'b0, 1'b1, "R7 canonical->hole");
      // R3: pointer-width bit ignored with translation off
      access({shr_base, 16'h0010}, 6'd0, 1'b0, 1'b1, 1'b1, "R3 ptr32 ignored");
      // R3: upper bits ignored in 32-bit mode
      access(64'hDEAD_0000_8000_0010, 6'd0, 1'b1, 1'b1, 1'b1, "R3 narrow upper junk");
      access(64'h4000_0000_0000_0100, 6'd0, 1'b1, 1'b1, 1'b1, "R3 narrow no hole");
      // R5: single 64KB page windows
      access(64'h0000_0000_8001_FFFF, 6'd0, 1'b1, 1'b1, 1'b1, "R5 private page end");
      access(64'h0000_0000_8002_0000, 6'd0, 1'b1, 1'b1, 1'b1, "R5 beyond private page");
      access(64'h0000_0000_8000_FFF8, 6'd15, 1'b1, 1'b1, 1'b1, "R7 narrow shared->private");
      access(64'h0000_0000_FFFF_FFF0, 6'd31, 1'b1, 1'b1, 1'b1, "R7 narrow wrap");
      // R5: zero page disables the window even for page 0
      shr32 = 16'h0;
      access(64'h0000_0000_0000_0010, 6'd0, 1'b1, 1'b1, 1'b1, "R5 disabled shared page0");
      shr32 = 16'h8000;

      for (int i = 0; i < 1800; i++) begin
         bit atc, p32, flat;
         if (i == 1200) begin shr32 = 16'h0; prv32 = 16'h0; end
         if (i == 1400) begin shr32 = 16'h0007; prv32 = 16'hFFFF; end
         if (i == 1600) begin
            shr_base = 48'h8000_0000_0000; shr_lim = 48'h8000_0000_0000;
            prv_base = 48'h8000_0000_0001; prv_lim = 48'h8000_0000_0003;
         end
         atc  = 1'($urandom);
         p32  = 1'($urandom);
         flat = ($urandom % 4) != 0;
         if (($urandom % 16) == 0) idle("R2 random idle");
         access(pick_addr(atc && p32), 6'($urandom), atc, p32, flat,
                "R4 R5 R6 R7 R8 R9 R10 random");
      end
      idle("R2 final idle");
      finish_run();
   end

endmodule